// File: doc/BRIEF.md
# I2C Register-Pointer Slave Front End

This block is the serial host port of a small controller. It listens on an I2C bus as a slave. It answers a 7-bit device address whose upper five bits are fixed at 0,1,1,0,1 and whose two low bits come from strap inputs, so four copies can share one bus. After a matched write address, the first byte of the frame loads a 5-bit register pointer. Every later byte of the frame is written at that pointer. A read frame returns the byte at the pointer. The pointer then steps forward, with special rules at location 00h, on pointer loads, and past the top of the map.

The block holds the small configuration map itself: status, error, version, control, two acknowledge-mask registers and configuration. The status register reflects core inputs. The error register latches codes reported by the core. Locations 07h to 19h form a data window. The block does not store that window: accesses to it are passed to an external frame buffer over a byte-wide bus with index, write strobe, read strobe and data. A one-cycle pulse marks each STOP on the bus. SCL and SDA are sampled through synchronisers on the system clock. SDA is driven only as a low-enable for an external open-drain pad.

Top module: `i2cs_regport`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {0,1,1,0,1,strap[1],strap[0]} (MSB first). On any other address it never enables the SDA pull-down until the next START.
- R2: After a matched write address, the first byte of the frame loads the pointer from its bits 4..0. Bits 7..5 of that byte are ignored.
- R3: At pointer 00h the pointer does not step. A read there returns status {BUSY in bit 7, pending interrupt in bit 6, ERR in bit 5, zeros in bits 4..0}, and data writes there are ignored.
- R4: Each data byte written or read at a nonzero pointer steps the pointer by one. The pointer keeps its value across STOP, START and repeated START, so a read frame with no pointer byte continues where the last access left it.
- R5: A pointer byte whose low five bits exceed 07h loads 07h instead.
- R6: Register 03h holds a reset request in bit 7 and an enable in bit 6. Register 04h holds mask bits 14..8 in its bits 6..0. Register 05h holds mask bits 7..0. All three reset to zero, read back what was written, and read unused bits as zero. Their fields appear on output ports.
- R7: Register 06h holds an error-report enable in bit 4 and a 3-bit retry count in bits 2..0. It resets to zero and reads its other bits as zero.
- R8: Pointers 07h to 19h map to window index pointer-7, with a one-cycle window write or read strobe per byte. Above 19h, writes are dropped and reads return FFh. The pointer never wraps back to 00h by stepping.
- R9: An error report from the core loads its code into register 01h and sets ERR. A read of 01h clears ERR, and a report in the same cycle wins over the clear.
- R10: Register 02h reads {major version in bits 7..4, minor version in bits 3..0}. Writes to 01h and 02h change nothing.
- R11: Each STOP condition gives exactly one single-cycle pulse on stop_o.
- R12: A master NACK after a read byte ends the transfer. The slave releases SDA and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Low two device-address bits |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| busy_i | input | 1 | Core busy, shown in status bit 7 |
| intp_i | input | 1 | Core interrupt pending, shown in status bit 6 |
| err_set_i | input | 1 | Core error report strobe |
| err_code_i | input | 8 | Error code captured with err_set_i |
| win_addr_o | output | 5 | Window index (pointer minus 7) |
| win_wr_o | output | 1 | Window byte write strobe |
| win_rd_o | output | 1 | Window byte fetch strobe |
| win_wdata_o | output | 8 | Window write data |
| win_rdata_i | input | 8 | Window read data for the current index |
| stop_o | output | 1 | One-cycle pulse per STOP condition |
| ctl_reset_o | output | 1 | Control register reset-request bit |
| ctl_enable_o | output | 1 | Control register enable bit |
| ack_mask_o | output | 15 | Logical-address acknowledge mask |
| cfg_err_en_o | output | 1 | Error-report enable |
| cfg_retry_o | output | 3 | Retry count |

## Verification
The hardest state to reach is a pointer beyond the top of the map. The pointer can never be loaded there, because loads clamp to 07h, so it is only reached by stepping. The stimulus therefore runs single contiguous frames of more than nineteen bytes from 07h, both writing and reading. It checks that the window sees exactly nineteen strobes, that the extra reads return FFh, and that a later frame with no pointer byte still reads FFh rather than wrapping to status. The clamp itself is swept over every pointer value from 07h to 1Fh with the reserved bits set. A master NACK in the middle of a read is also provoked, and the SDA release and the pointer position are then checked.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_WR, PH_WACK, PH_RD, PH_RACK
  } phase_t;

  localparam logic [4:0] RA_STAT = 5'h00;
  localparam logic [4:0] RA_ERR  = 5'h01;
  localparam logic [4:0] RA_VER  = 5'h02;
  localparam logic [4:0] RA_CTL  = 5'h03;
  localparam logic [4:0] RA_MSKH = 5'h04;
  localparam logic [4:0] RA_MSKL = 5'h05;
  localparam logic [4:0] RA_CFG  = 5'h06;
endpackage

// File: rtl/i2cs_bitlink.sv
module i2cs_bitlink
  import i2cs_pkg::*;
#(
  parameter logic [4:0] DEV_CODE = 5'b01101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic       wr_first_o,
  output logic [7:0] wr_data_o,
  output logic       rd_stb_o,
  output logic       stop_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       rise, fall, start_det, stop_det;

  phase_t     ph, ph_n;
  logic [3:0] bitcnt, bitcnt_n;
  logic [7:0] shreg, shreg_n;
  logic       rnw, rnw_n, wfirst, wfirst_n, oe, oe_n;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    ph_n     = ph;
    bitcnt_n = bitcnt;
    shreg_n  = shreg;
    rnw_n    = rnw;
    wfirst_n = wfirst;
    oe_n     = oe;
    wr_stb_o = 1'b0;
    rd_stb_o = 1'b0;
    stop_o   = 1'b0;
    if (stop_det) begin
      ph_n   = PH_IDLE;
      oe_n   = 1'b0;
      stop_o = 1'b1;
    end else if (start_det) begin
      ph_n     = PH_ADDR;
      bitcnt_n = 4'd0;
      oe_n     = 1'b0;
    end else begin
      case (ph)
        PH_ADDR, PH_WR: begin
          if (rise) begin
            shreg_n  = {shreg[6:0], sda_s};
            bitcnt_n = bitcnt + 4'd1;
          end else if (fall && bitcnt == 4'd8) begin
            if (ph == PH_ADDR) begin
              if (shreg[7:1] == {DEV_CODE, strap_i}) begin
                oe_n  = 1'b1;
                rnw_n = shreg[0];
                ph_n  = PH_AACK;
              end else begin
                ph_n = PH_IDLE;
              end
            end else begin
              oe_n     = 1'b1;
              wr_stb_o = 1'b1;
              ph_n     = PH_WACK;
            end
          end
        end
        PH_AACK: begin
          if (fall) begin
            bitcnt_n = 4'd0;
            if (rnw) begin
              shreg_n  = rd_byte_i;
              rd_stb_o = 1'b1;
              oe_n     = ~rd_byte_i[7];
              ph_n     = PH_RD;
            end else begin
              oe_n     = 1'b0;
              wfirst_n = 1'b1;
              ph_n     = PH_WR;
            end
          end
        end
        PH_WACK: begin
          if (fall) begin
            oe_n     = 1'b0;
            bitcnt_n = 4'd0;
            wfirst_n = 1'b0;
            ph_n     = PH_WR;
          end
        end
        PH_RD: begin
          if (rise) begin
            bitcnt_n = bitcnt + 4'd1;
          end else if (fall) begin
            if (bitcnt == 4'd8) begin
              oe_n = 1'b0;
              ph_n = PH_RACK;
            end else begin
              shreg_n = {shreg[6:0], 1'b0};
              oe_n    = ~shreg[6];
            end
          end
        end
        PH_RACK: begin
          if (rise && sda_s) begin
            ph_n = PH_IDLE;
          end else if (fall) begin
            bitcnt_n = 4'd0;
            shreg_n  = rd_byte_i;
            rd_stb_o = 1'b1;
            oe_n     = ~rd_byte_i[7];
            ph_n     = PH_RD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ph     <= PH_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'd0;
      rnw    <= 1'b0;
      wfirst <= 1'b0;
      oe     <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      ph     <= ph_n;
      bitcnt <= bitcnt_n;
      shreg  <= shreg_n;
      rnw    <= rnw_n;
      wfirst <= wfirst_n;
      oe     <= oe_n;
    end
  end

  assign sda_oe_o   = oe;
  assign wr_first_o = wfirst;
  assign wr_data_o  = shreg;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> !oe); // R1
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RACK && rise && sda_s) |=> (!oe && ph == PH_IDLE)); // R12
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && rd_stb_o)); // R4
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o); // R11
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int         PTR_W    = 5,
  parameter int         WIN_BASE = 7,
  parameter int         WIN_TOP  = 25,
  parameter logic [3:0] VER_MAJ  = 4'h1,
  parameter logic [3:0] VER_MIN  = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb_i,
  input  logic             wr_first_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_stb_i,
  input  logic             busy_i,
  input  logic             intp_i,
  input  logic             err_set_i,
  input  logic [7:0]       err_code_i,
  input  logic [7:0]       win_rdata_i,
  output logic [7:0]       rd_byte_o,
  output logic [PTR_W-1:0] win_addr_o,
  output logic             win_wr_o,
  output logic             win_rd_o,
  output logic [7:0]       win_wdata_o,
  output logic             ctl_reset_o,
  output logic             ctl_enable_o,
  output logic [14:0]      ack_mask_o,
  output logic             cfg_err_en_o,
  output logic [2:0]       cfg_retry_o
);
  localparam logic [PTR_W-1:0] BASE_P = PTR_W'(WIN_BASE);
  localparam logic [PTR_W-1:0] TOP_P  = PTR_W'(WIN_TOP);
  localparam logic [PTR_W-1:0] MAX_P  = {PTR_W{1'b1}};

  logic [PTR_W-1:0] ptr, ptr_n, ptr_step;
  logic             err_flag, err_flag_n;
  logic [7:0]       err_code, err_code_n;
  logic [1:0]       ctl, ctl_n;
  logic [6:0]       mskh, mskh_n;
  logic [7:0]       mskl, mskl_n;
  logic             cfg_en, cfg_en_n;
  logic [2:0]       retry, retry_n;
  logic             in_win, ptr_load, data_wr;

  assign in_win   = (ptr >= BASE_P) && (ptr <= TOP_P);
  assign ptr_load = wr_stb_i & wr_first_i;
  assign data_wr  = wr_stb_i & ~wr_first_i;
  assign ptr_step = (ptr == '0 || ptr == MAX_P) ? ptr : ptr + PTR_W'(1);

  always_comb begin
    ptr_n      = ptr;
    err_flag_n = err_flag;
    err_code_n = err_code;
    ctl_n      = ctl;
    mskh_n     = mskh;
    mskl_n     = mskl;
    cfg_en_n   = cfg_en;
    retry_n    = retry;
    if (ptr_load) begin
      ptr_n = (wr_data_i[PTR_W-1:0] > BASE_P) ? BASE_P : wr_data_i[PTR_W-1:0];
    end else if (data_wr || rd_stb_i) begin
      ptr_n = ptr_step;
    end
    if (data_wr) begin
      case (ptr)
        RA_CTL:  ctl_n = wr_data_i[7:6];
        RA_MSKH: mskh_n = wr_data_i[6:0];
        RA_MSKL: mskl_n = wr_data_i;
        RA_CFG: begin
          cfg_en_n = wr_data_i[4];
          retry_n  = wr_data_i[2:0];
        end
        default: ;
      endcase
    end
    if (err_set_i) begin
      err_flag_n = 1'b1;
      err_code_n = err_code_i;
    end else if (rd_stb_i && ptr == RA_ERR) begin
      err_flag_n = 1'b0;
    end
  end

  always_comb begin
    case (ptr)
      RA_STAT: rd_byte_o = {busy_i, intp_i, err_flag, 5'b0};
      RA_ERR:  rd_byte_o = err_code;
      RA_VER:  rd_byte_o = {VER_MAJ, VER_MIN};
      RA_CTL:  rd_byte_o = {ctl, 6'b0};
      RA_MSKH: rd_byte_o = {1'b0, mskh};
      RA_MSKL: rd_byte_o = mskl;
      RA_CFG:  rd_byte_o = {3'b0, cfg_en, 1'b0, retry};
      default: rd_byte_o = in_win ? win_rdata_i : 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      err_flag <= 1'b0;
      err_code <= 8'd0;
      ctl      <= 2'd0;
      mskh     <= 7'd0;
      mskl     <= 8'd0;
      cfg_en   <= 1'b0;
      retry    <= 3'd0;
    end else begin
      ptr      <= ptr_n;
      err_flag <= err_flag_n;
      err_code <= err_code_n;
      ctl      <= ctl_n;
      mskh     <= mskh_n;
      mskl     <= mskl_n;
      cfg_en   <= cfg_en_n;
      retry    <= retry_n;
    end
  end

  assign win_addr_o   = ptr - BASE_P;
  assign win_wr_o     = data_wr & in_win;
  assign win_rd_o     = rd_stb_i & in_win;
  assign win_wdata_o  = wr_data_i;
  assign ctl_reset_o  = ctl[1];
  assign ctl_enable_o = ctl[0];
  assign ack_mask_o   = {mskh, mskl};
  assign cfg_err_en_o = cfg_en;
  assign cfg_retry_o  = retry;

  AST_PTR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (ptr <= BASE_P)); // R5
  AST_PTR_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '0 && !ptr_load) |=> (ptr == '0)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != '0 && !ptr_load) |=> (ptr != '0)); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && ptr == RA_ERR && !err_set_i) |=> !err_flag); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_i |=> (err_flag && err_code == $past(err_code_i))); // R9
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport #(
  parameter logic [4:0] DEV_CODE = 5'b01101,
  parameter logic [3:0] VER_MAJ  = 4'h1,
  parameter logic [3:0] VER_MIN  = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  strap_i,
  output logic        sda_oe_o,
  input  logic        busy_i,
  input  logic        intp_i,
  input  logic        err_set_i,
  input  logic [7:0]  err_code_i,
  output logic [4:0]  win_addr_o,
  output logic        win_wr_o,
  output logic        win_rd_o,
  output logic [7:0]  win_wdata_o,
  input  logic [7:0]  win_rdata_i,
  output logic        stop_o,
  output logic        ctl_reset_o,
  output logic        ctl_enable_o,
  output logic [14:0] ack_mask_o,
  output logic        cfg_err_en_o,
  output logic [2:0]  cfg_retry_o
);
  logic [1:0] rst_sy;
  logic       rst_q;
  logic       wr_stb, wr_first, rd_stb;
  logic [7:0] wr_data, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= 2'b00;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_q = rst_sy[1];

  i2cs_bitlink #(.DEV_CODE(DEV_CODE)) u_link (
    .clk        (clk),
    .rst_n      (rst_q),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .strap_i    (strap_i),
    .rd_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb),
    .wr_first_o (wr_first),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb),
    .stop_o     (stop_o)
  );

  i2cs_regbank #(
    .PTR_W    (5),
    .WIN_BASE (7),
    .WIN_TOP  (25),
    .VER_MAJ  (VER_MAJ),
    .VER_MIN  (VER_MIN)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_q),
    .wr_stb_i     (wr_stb),
    .wr_first_i   (wr_first),
    .wr_data_i    (wr_data),
    .rd_stb_i     (rd_stb),
    .busy_i       (busy_i),
    .intp_i       (intp_i),
    .err_set_i    (err_set_i),
    .err_code_i   (err_code_i),
    .win_rdata_i  (win_rdata_i),
    .rd_byte_o    (rd_byte),
    .win_addr_o   (win_addr_o),
    .win_wr_o     (win_wr_o),
    .win_rd_o     (win_rd_o),
    .win_wdata_o  (win_wdata_o),
    .ctl_reset_o  (ctl_reset_o),
    .ctl_enable_o (ctl_enable_o),
    .ack_mask_o   (ack_mask_o),
    .cfg_err_en_o (cfg_err_en_o),
    .cfg_retry_o  (cfg_retry_o)
  );
endmodule

// File: tb/i2cs_regport_test.sv
`timescale 1ns/1ps
module i2cs_regport_test;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda;
  logic [1:0]  strap;
  logic        sda_oe;
  logic        busy, intp, err_set;
  logic [7:0]  err_code;
  logic [4:0]  win_addr;
  logic        win_wr, win_rd;
  logic [7:0]  win_wdata, win_rdata;
  logic        stop_p, ctl_rst, ctl_en, cfg_en;
  logic [14:0] mask;
  logic [2:0]  retry;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int wcnt = 0;
  int scnt = 0;
  logic [7:0] wmem [0:31];
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:31];

  always #5 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign win_rdata = 8'h40 + {3'b0, win_addr};

  i2cs_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe_o(sda_oe), .busy_i(busy), .intp_i(intp), .err_set_i(err_set),
    .err_code_i(err_code), .win_addr_o(win_addr), .win_wr_o(win_wr),
    .win_rd_o(win_rd), .win_wdata_o(win_wdata), .win_rdata_i(win_rdata),
    .stop_o(stop_p), .ctl_reset_o(ctl_rst), .ctl_enable_o(ctl_en),
    .ack_mask_o(mask), .cfg_err_en_o(cfg_en), .cfg_retry_o(retry)
  );

  always @(posedge clk) begin
    if (win_wr) begin
      wmem[win_addr] <= win_wdata;
      wcnt <= wcnt + 1;
    end
    if (stop_p) scnt <= scnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_rstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      m_scl = 1'b0;
    end
    m_sda = nack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {5'b01101, strap, rw};
  endfunction

  task automatic wr_frame(input logic [7:0] p, input int n);
    logic a;
    i2c_start();
    send_byte(dev(1'b0), a);
    send_byte(p, a);
    for (int i = 0; i < n; i++) send_byte(wbuf[i], a);
    i2c_stop();
  endtask

  task automatic rd_frame(input int n);
    logic a;
    i2c_start();
    send_byte(dev(1'b1), a);
    for (int i = 0; i < n; i++) recv_byte(i == n-1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic ptr_rd(input logic [7:0] p, input int n);
    logic a;
    i2c_start();
    send_byte(dev(1'b0), a);
    send_byte(p, a);
    i2c_rstart();
    send_byte(dev(1'b1), a);
    for (int i = 0; i < n; i++) recv_byte(i == n-1, rbuf[i]);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    logic [7:0] vals [0:5];
    int w0;
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h5A;
    vals[3] = 8'hA5; vals[4] = 8'hC3; vals[5] = 8'h3C;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 2'b10;
    busy = 1'b0; intp = 1'b0; err_set = 1'b0; err_code = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // reset state: R6 R7
    chk("R6 reset sda", {15'b0, sda_oe}, 16'h0);
    chk("R6 reset ctl", {14'b0, ctl_rst, ctl_en}, 16'h0);
    chk("R6 reset mask", {1'b0, mask}, 16'h0);
    chk("R7 reset cfg", {12'b0, cfg_en, retry}, 16'h0);
    rd_frame(1);
    chk("R3 reset status", {8'h0, rbuf[0]}, 16'h0);

    // R1: address match sweep
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        strap = 2'(s);
        i2c_start();
        send_byte({5'b01101, 2'(t), 1'b0}, a);
        i2c_stop();
        chk("R1 address ack", {15'b0, a}, {15'b0, (s == t)});
      end
    end
    i2c_start();
    send_byte(8'hA0, a);
    chk("R1 foreign code nack", {15'b0, a}, 16'h0);
    i2c_stop();
    chk("R1 released after", {15'b0, sda_oe}, 16'h0);
    strap = 2'b01;

    // R6 R7 write sweep and read back
    for (int k = 0; k < 6; k++) begin
      v = vals[k];
      for (int i = 0; i < 4; i++) wbuf[i] = v;
      wr_frame(8'h03, 4);
      chk("R6 ctl port", {14'b0, ctl_rst, ctl_en}, {14'b0, v[7:6]});
      chk("R6 mask port", {1'b0, mask}, {1'b0, v[6:0], v});
      chk("R7 cfg port", {12'b0, cfg_en, retry}, {12'b0, v[4], v[2:0]});
      ptr_rd(8'h03, 4);
      chk("R6 ctl read", {8'h0, rbuf[0]}, {8'h0, v[7:6], 6'b0});
      chk("R6 maskh read", {8'h0, rbuf[1]}, {8'h0, 1'b0, v[6:0]});
      chk("R6 maskl read", {8'h0, rbuf[2]}, {8'h0, v});
      chk("R7 cfg read", {8'h0, rbuf[3]}, {8'h0, 3'b0, v[4], 1'b0, v[2:0]});
    end

    // R3 polling at 00h
    wbuf[0] = 8'hFF;
    wr_frame(8'h00, 1);
    for (int c = 0; c < 4; c++) begin
      busy = c[1]; intp = c[0];
      rd_frame(3);
      for (int i = 0; i < 3; i++)
        chk("R3 status poll", {8'h0, rbuf[i]}, {8'h0, busy, intp, 6'b0});
    end
    busy = 1'b0; intp = 1'b0;

    // R4 persistence across frames and repeated start (mask = 3C from last sweep)
    ptr_rd(8'h04, 1);
    rd_frame(1);
    chk("R4 continue frame", {8'h0, rbuf[0]}, 16'h003C);
    rd_frame(1);
    chk("R4 continue cfg", {8'h0, rbuf[0]}, 16'h0014);
    ptr_rd(8'hE4, 1);
    chk("R2 reserved bits ignored", {8'h0, rbuf[0]}, 16'h003C);

    // R5 clamp sweep
    for (int p = 7; p < 32; p++) begin
      ptr_rd(8'hE0 | 8'(p), 1);
      chk("R5 clamp to 07h", {8'h0, rbuf[0]}, 16'h0040);
    end

    // R8 window write beyond top
    for (int i = 0; i < 21; i++) wbuf[i] = 8'h10 + 8'(i);
    w0 = wcnt;
    wr_frame(8'h07, 21);
    chk("R8 window write count", 16'(wcnt - w0), 16'd19);
    for (int i = 0; i < 19; i += 6)
      chk("R8 window data", {8'h0, wmem[i]}, {8'h0, 8'h10 + 8'(i)});
    chk("R8 window last", {8'h0, wmem[18]}, 16'h0022);
    ptr_rd(8'h07, 21);
    for (int i = 0; i < 21; i++)
      chk("R8 window read", {8'h0, rbuf[i]}, (i < 19) ? {8'h0, 8'h40 + 8'(i)} : 16'h00FF);
    rd_frame(2);
    chk("R8 no wrap", {8'h0, rbuf[0]}, 16'h00FF);
    chk("R8 no wrap 2", {8'h0, rbuf[1]}, 16'h00FF);

    // R9 error flag
    @(negedge clk); err_set = 1'b1; err_code = 8'h02;
    @(negedge clk); err_set = 1'b0; err_code = 8'h00;
    ptr_rd(8'h00, 1);
    chk("R9 err set", {8'h0, rbuf[0]}, 16'h0020);
    rd_frame(1);
    chk("R9 err holds", {8'h0, rbuf[0]}, 16'h0020);
    ptr_rd(8'h01, 1);
    chk("R9 err code", {8'h0, rbuf[0]}, 16'h0002);
    ptr_rd(8'h00, 1);
    chk("R9 err cleared", {8'h0, rbuf[0]}, 16'h0000);
    wbuf[0] = 8'h55;
    wr_frame(8'h01, 1);
    ptr_rd(8'h01, 1);
    chk("R10 err reg write ignored", {8'h0, rbuf[0]}, 16'h0002);

    // R10 version
    ptr_rd(8'h02, 1);
    chk("R10 version", {8'h0, rbuf[0]}, 16'h0012);
    wbuf[0] = 8'h00;
    wr_frame(8'h02, 1);
    ptr_rd(8'h02, 1);
    chk("R10 version write ignored", {8'h0, rbuf[0]}, 16'h0012);

    // R11 stop pulse count
    w0 = scnt;
    wr_frame(8'h03, 0);
    tick(2);
    chk("R11 stop pulses", 16'(scnt - w0), 16'd1);

    // R12 NACK mid read
    i2c_start();
    send_byte(dev(1'b0), a);
    send_byte(8'h03, a);
    i2c_rstart();
    send_byte(dev(1'b1), a);
    recv_byte(1'b0, rbuf[0]);
    recv_byte(1'b1, rbuf[1]);
    tick(Q);
    chk("R12 released after nack", {15'b0, sda_oe}, 16'h0);
    i2c_stop();
    chk("R12 byte before nack", {8'h0, rbuf[1]}, 16'h003C);
    rd_frame(1);
    chk("R12 pointer after nack", {8'h0, rbuf[0]}, 16'h003C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule